// File: doc/BRIEF.md
# Interrupt Status and Mask Register Block

This block collects ten interrupt sources into one level-sensitive interrupt line. It sits on a simple 32-bit register bus. The bus has single-cycle write and read strobes and a word address. Hardware event pulses and software triggers set the status bits. Software clears them by writing ones. Each source has a mask bit. Software can read the mask, but cannot write it directly. It changes the mask only through two command words: one clears the given mask bits and the other sets them.

The interrupt output is a registered signal. It is high when at least one status bit is set and its mask bit is clear. It follows every status or mask change one clock later. Read data is also registered: a read strobe at an edge captures the register contents from before that edge's updates. The captured value holds until the next read strobe. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset, status reads 0x000, mask reads 0x3FF and `irq` is low.
- R2: Writing status (word 0) clears every status bit whose written bit is one. Bits written as zero are unchanged.
- R3: Writing the enable command (word 2) clears every mask bit whose written bit is one.
- R4: Writing the disable command (word 3) sets every mask bit whose written bit is one.
- R5: Writing the trigger command (word 4) sets every status bit whose written bit is one.
- R6: In the cycle after any status or mask change, `irq` equals the OR over all sources of (status AND NOT mask).
- R7: Words 2, 3 and 4 read as zero. Writes to the mask word (word 1) have no effect.
- R8: A high `hw_evt` bit sets its status bit. If a clear of that bit arrives in the same cycle, the set wins.
- R9: Reads from words 5 to 15 return zero. Writes to those words change no state.
- R10: Read bits 31:10 are always zero. Written bits 31:10 have no effect.
- R11: When `rd_en` is high at an edge, `rdata` takes the addressed word's value from before that edge. When `rd_en` is low, `rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| hw_evt | input | 10 | Hardware event inputs, one per source |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
The bench targets a hardware event that arrives in the same cycle as a software clear of that bit. A design that lets the clear win loses the event, and the status readback shows it. A mask write through the readable mask word must leave the mask unchanged; a design that accepts it is caught. Trigger bits above bit 9 and writes to undefined words must also change nothing, and a design that lets either leak in shows extra set bits on readback. The bench also issues a read and a write to the same word in one cycle. The read must return the old value; returning the new one breaks the registered-read ordering, and a reference model compared on every clock exposes it.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;

  // Word offsets of the register set
  typedef enum logic [2:0] {
    OFS_STATUS  = 3'd0,
    OFS_MASK    = 3'd1,
    OFS_ENABLE  = 3'd2,
    OFS_DISABLE = 3'd3,
    OFS_TRIGGER = 3'd4
  } reg_ofs_e;

  // Decoded one-cycle strobes
  typedef struct packed {
    logic st_clr;
    logic st_set;
    logic mk_clr;
    logic mk_set;
    logic rd_st;
    logic rd_mk;
  } strobe_t;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
  import irq_mask_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           stb
);

  localparam int OFS_W = $bits(reg_ofs_e);

  logic upper_zero;
  logic [OFS_W-1:0] low;

  generate
    if (ADDR_W > OFS_W) begin : g_wide
      assign upper_zero = (addr[ADDR_W-1:OFS_W] == '0);
      assign low        = addr[OFS_W-1:0];
    end else begin : g_narrow
      assign upper_zero = 1'b1;
      assign low        = OFS_W'(addr);
    end
  endgenerate

  always_comb begin
    stb = '0;
    if (upper_zero) begin
      stb.st_clr = wr_en && (low == OFS_STATUS);
      stb.mk_clr = wr_en && (low == OFS_ENABLE);
      stb.mk_set = wr_en && (low == OFS_DISABLE);
      stb.st_set = wr_en && (low == OFS_TRIGGER);
      stb.rd_st  = rd_en && (low == OFS_STATUS);
      stb.rd_mk  = rd_en && (low == OFS_MASK);
    end
  end

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int NUM_SRC = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_en,
  input  logic               set_en,
  input  logic [NUM_SRC-1:0] wbits,
  input  logic [NUM_SRC-1:0] hw_evt,
  output logic [NUM_SRC-1:0] status_d,
  output logic [NUM_SRC-1:0] status_q
);

  genvar i;
  generate
    for (i = 0; i < NUM_SRC; i++) begin : g_bit
      logic set_i;
      logic clr_i;
      assign set_i = hw_evt[i] | (set_en & wbits[i]);
      assign clr_i = clr_en & wbits[i];

      // a set in the same cycle as a clear takes priority
      always_comb begin
        if (set_i)      status_d[i] = 1'b1;
        else if (clr_i) status_d[i] = 1'b0;
        else            status_d[i] = status_q[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              status_q[i] <= 1'b0;
        else if (set_i || clr_i) status_q[i] <= status_d[i];
      end
    end
  endgenerate

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int NUM_SRC = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_en,
  input  logic               set_en,
  input  logic [NUM_SRC-1:0] wbits,
  output logic [NUM_SRC-1:0] mask_d,
  output logic [NUM_SRC-1:0] mask_q
);

  genvar i;
  generate
    for (i = 0; i < NUM_SRC; i++) begin : g_bit
      logic upd_i;
      assign upd_i = (clr_en | set_en) & wbits[i];

      always_comb begin
        if (set_en && wbits[i])      mask_d[i] = 1'b1;
        else if (clr_en && wbits[i]) mask_d[i] = 1'b0;
        else                         mask_d[i] = mask_q[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     mask_q[i] <= 1'b1;
        else if (upd_i) mask_q[i] <= mask_d[i];
      end
    end
  endgenerate

endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irq_mask_pkg::*;
#(
  parameter int NUM_SRC = 10,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_SRC-1:0] hw_evt,
  output logic [DATA_W-1:0]  rdata,
  output logic               irq
);

  localparam int PAD_W = DATA_W - NUM_SRC;

  logic               rst_sync_n;
  strobe_t            stb;
  logic [NUM_SRC-1:0] wbits;
  logic [NUM_SRC-1:0] status_d, status_q;
  logic [NUM_SRC-1:0] mask_d, mask_q;
  logic [DATA_W-1:0]  rd_mux;
  logic [DATA_W-1:0]  rdata_q;
  logic               irq_d, irq_q;

  assign wbits = wdata[NUM_SRC-1:0];

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .stb   (stb)
  );

  irq_status_bank #(.NUM_SRC(NUM_SRC)) u_status (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr_en   (stb.st_clr),
    .set_en   (stb.st_set),
    .wbits    (wbits),
    .hw_evt   (hw_evt),
    .status_d (status_d),
    .status_q (status_q)
  );

  irq_mask_bank #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr_en (stb.mk_clr),
    .set_en (stb.mk_set),
    .wbits  (wbits),
    .mask_d (mask_d),
    .mask_q (mask_q)
  );

  // read mux: unlisted and command words return zero
  always_comb begin
    rd_mux = '0;
    if (stb.rd_st)      rd_mux = {{PAD_W{1'b0}}, status_q};
    else if (stb.rd_mk) rd_mux = {{PAD_W{1'b0}}, mask_q};
  end

  // interrupt computed from next state so it tracks each update
  always_comb begin
    irq_d = |(status_d & ~mask_d);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else if (rd_en)  rdata_q <= rd_mux;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) irq_q <= 1'b0;
    else             irq_q <= irq_d;
  end

  assign rdata = rdata_q;
  assign irq   = irq_q;

endmodule

// File: rtl/irq_mask_ctrl_chk.sv
module irq_mask_ctrl_chk #(
  parameter int NUM_SRC = 10,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wdata,
  input logic [NUM_SRC-1:0] hw_evt,
  input logic [DATA_W-1:0]  rdata,
  input logic               irq,
  input logic [NUM_SRC-1:0] status_q,
  input logic [NUM_SRC-1:0] mask_q
);

  p_irq_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(status_q & ~mask_q));

  p_evt_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_evt) |=> ((status_q & $past(hw_evt)) == $past(hw_evt)));

  p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == ADDR_W'(2) || addr == ADDR_W'(3))) |=> $stable(mask_q));

  p_trigger_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(4)) |=>
      ((status_q & $past(wdata[NUM_SRC-1:0])) == $past(wdata[NUM_SRC-1:0])));

  p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-1:NUM_SRC] == '0);

  p_cmd_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr >= ADDR_W'(2)) |=> (rdata == '0));

endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk #(
  .NUM_SRC (NUM_SRC),
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .addr     (addr),
  .wdata    (wdata),
  .hw_evt   (hw_evt),
  .rdata    (rdata),
  .irq      (irq),
  .status_q (status_q),
  .mask_q   (mask_q)
);

// File: tb/irq_mask_ctrl_test.sv
module irq_mask_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int N = 10;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic        rd_en;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic [N-1:0] hw_evt;
  logic [31:0] rdata;
  logic        irq;

  int checks;
  int errors;
  bit cmp_on;

  // reference model state
  bit [N-1:0] m_st;
  bit [N-1:0] m_mk;
  bit [31:0]  m_rd;
  bit         m_irq;

  irq_mask_ctrl uut (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .wdata  (wdata),
    .hw_evt (hw_evt),
    .rdata  (rdata),
    .irq    (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // behavioural model, one step per rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = '0; m_mk = '1; m_rd = '0; m_irq = 1'b0;
    end else begin
      if (rd_en) begin
        case (addr)
          4'd0:    m_rd = {22'd0, m_st};
          4'd1:    m_rd = {22'd0, m_mk};
          default: m_rd = '0;
        endcase
      end
      if (wr_en) begin
        case (addr)
          4'd0: m_st = m_st & ~wdata[N-1:0];
          4'd2: m_mk = m_mk & ~wdata[N-1:0];
          4'd3: m_mk = m_mk | wdata[N-1:0];
          4'd4: m_st = m_st | wdata[N-1:0];
          default: ;
        endcase
      end
      m_st  = m_st | hw_evt;
      m_irq = |(m_st & ~m_mk);
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (cmp_on) begin
      check("R6 irq vs model", {31'd0, irq}, {31'd0, m_irq});
      check("R11 rdata vs model", rdata, m_rd);
    end
  end

  // one bus cycle, called at a falling edge
  task automatic bus(input logic we, input logic re, input logic [3:0] a,
                     input logic [31:0] d, input logic [N-1:0] ev);
    wr_en = we; rd_en = re; addr = a; wdata = d; hw_evt = ev;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; hw_evt = '0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus(1'b1, 1'b0, a, d, '0);
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    bus(1'b0, 1'b1, a, '0, '0);
    check(tag, rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0; cmp_on = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; hw_evt = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_on = 1'b1;

    check("R1 irq after reset", {31'd0, irq}, 32'd0);
    rd_chk(4'd0, 32'h000, "R1 status reset");
    rd_chk(4'd1, 32'h3FF, "R1 mask reset");

    wr(4'd4, 32'h005);
    rd_chk(4'd0, 32'h005, "R5 trigger sets status");
    check("R6 irq low while masked", {31'd0, irq}, 32'd0);

    wr(4'd2, 32'h001);
    check("R6 irq after enable", {31'd0, irq}, 32'd1);
    rd_chk(4'd1, 32'h3FE, "R3 enable clears mask bit");

    wr(4'd3, 32'h001);
    check("R6 irq after disable", {31'd0, irq}, 32'd0);
    rd_chk(4'd1, 32'h3FF, "R4 disable sets mask bit");

    wr(4'd2, 32'h3FF);
    wr(4'd0, 32'h004);
    rd_chk(4'd0, 32'h001, "R2 write-one clears only ones");
    wr(4'd0, 32'h001);
    check("R6 irq drops when cleared", {31'd0, irq}, 32'd0);

    wr(4'd3, 32'h0F0);
    wr(4'd1, 32'hFFFF_FFFF);
    rd_chk(4'd1, 32'h0F0, "R7 mask word write ignored");
    rd_chk(4'd2, 32'h0, "R7 enable word reads zero");
    rd_chk(4'd3, 32'h0, "R7 disable word reads zero");
    rd_chk(4'd4, 32'h0, "R7 trigger word reads zero");

    bus(1'b0, 1'b0, 4'd0, 32'h0, 10'h200);
    rd_chk(4'd0, 32'h200, "R8 event sets status");
    bus(1'b1, 1'b0, 4'd0, 32'h200, 10'h200);
    rd_chk(4'd0, 32'h200, "R8 set wins over clear");
    bus(1'b1, 1'b0, 4'd0, 32'h200, 10'h001);
    rd_chk(4'd0, 32'h001, "R8 clear with other event");

    wr(4'd7, 32'hFFFF_FFFF);
    wr(4'd12, 32'hFFFF_FFFF);
    rd_chk(4'd0, 32'h001, "R9 undefined write no status change");
    rd_chk(4'd1, 32'h0F0, "R9 undefined write no mask change");
    rd_chk(4'd9, 32'h0, "R9 undefined word reads zero");

    wr(4'd4, 32'hFFFF_FC00);
    rd_chk(4'd0, 32'h001, "R10 upper trigger bits ignored");

    bus(1'b1, 1'b1, 4'd0, 32'h001, '0);
    check("R11 read returns pre-write value", rdata, 32'h001);
    @(negedge clk);
    check("R11 rdata holds without strobe", rdata, 32'h001);
    rd_chk(4'd0, 32'h000, "R11 later read sees write");

    for (int k = 0; k < 400; k++) begin
      logic [3:0] a;
      logic [N-1:0] ev;
      a  = 4'($urandom_range(0, 7));
      ev = ($urandom_range(0, 3) == 0) ? N'($urandom) : '0;
      bus(1'($urandom), 1'($urandom), a, $urandom, ev);
    end

    cmp_on = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule